// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shifter

This block is the serial engine behind a processor-controlled three-wire EEPROM port. Firmware loads a byte into the data register and then writes a control word. Each accepted control write starts exactly one shift operation of 0 to 8 bits. The operation is either a transmit or a receive, and the control word also says whether the bidirectional data line is released once the operation is done. The block generates the serial clock by dividing the system clock, runs a single left-shifting register for both directions, and owns the output enable of the data pin.

Chip select is not part of this block. Firmware drives it from a general-purpose output, raises it before the first command of a transaction and lowers it after the last. Between those two points it issues as many short commands as it needs. After a receive, the memory keeps driving the data line until chip select falls. A zero-length command with the release bit clear then hands the line back to this block: it turns the driver on at once and produces no clock pulse. The memory's opcode protocol is also handled by firmware.

Top module: `tw_eeprom_shifter`

## Requirements
- R1: After reset, ctl_rdata and dat_rdata read 0, sck_o is low and sda_oe is low.
- R2: The serial clock idles low. While a shift runs, its period is 2*HALF_DIV system clocks (500 kHz from 50 MHz with the default), and the first rising edge comes HALF_DIV clocks after busy rises.
- R3: A control write accepted while idle with a bit count above zero sets busy (ctl_rdata bit 7) on the next cycle. Busy then stays high for exactly 2*HALF_DIV*count cycles, and sck_o gives exactly count pulses.
- R4: A transmit (control bit 4 = 0) drives sda_oe high for the whole operation. Bits leave MSB first from data bit 7 and hold steady from one SCK falling edge to the next. The data register shifts left once per bit and fills with zeros.
- R5: A receive (control bit 4 = 1) keeps sda_oe low. sda_i is sampled at each SCK rising edge, and the result is (old << count) | received, with the first received bit most significant.
- R6: When an operation with a nonzero count ends, sda_oe is high only for a transmit with control bit 5 (release) clear.
- R7: A control write with count 0 gives no SCK pulse and never sets busy. It leaves the data register unchanged, and from the next cycle sda_oe equals the inverse of control bit 5.
- R8: A count field (control bits 3:0) above 8 is treated as 8, and ctl_rdata[3:0] then reads 8.
- R9: Control and data writes that arrive while busy is high are ignored.
- R10: A data write and a control write in the same idle cycle are both accepted, and the operation shifts the newly written data.
- R11: ctl_rdata reads {busy, 0, release, direction, count} with the count in bits 3:0, direction in bit 4, release in bit 5 and busy in bit 7, as last accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control word: count[3:0], direction[4], release[5] |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| ctl_rdata | output | 8 | Control/status readback |
| dat_rdata | output | 8 | Data register readback |
| sck_o | output | 1 | Serial clock to the EEPROM |
| sda_o | output | 1 | Serial data output value |
| sda_oe | output | 1 | Serial data output enable |
| sda_i | input | 1 | Serial data input from the pin |

## Verification
Two collisions matter. A register write can land in the middle of a running shift, and a data write can land in the same cycle as the control write that starts an operation. The bench provokes the first by pulsing both strobes part way through a 4-bit transmit. It then judges the bit count, busy duration, readback fields and final data value against the unpoked expectation. For the second, it loads fresh data on the starting cycle and requires that exactly those bits appear on the line. A scoreboard queue holds the expected serial bits and compares each one at the SCK rising edge.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int DW = 8;
  localparam int CW = 4;

  typedef struct packed {
    logic           hiz;
    logic           rd;
    logic [CW-1:0]  cnt;
  } tws_cmd_t;

  // Limit a requested bit count to the register width.
  function automatic logic [CW-1:0] clamp_cnt(input logic [CW-1:0] raw);
    return (raw > CW'(DW)) ? CW'(DW) : raw;
  endfunction

  // One shift step: the MSB leaves and the incoming bit enters at bit 0.
  function automatic logic [DW-1:0] shift_step(input logic [DW-1:0] cur,
                                               input logic in_bit);
    return {cur[DW-2:0], in_bit};
  endfunction

  // Driver state once a nonzero-length operation completes.
  function automatic logic drive_after(input logic rd, input logic hiz);
    return ~rd & ~hiz;
  endfunction

endpackage

// File: rtl/tws_clkgen.sv
module tws_clkgen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic             sck_q;
  logic             at_end;

  assign at_end  = (div_q == DIV_W'(HALF_DIV - 1));
  assign rise_ev = run & at_end & ~sck_q;
  assign fall_ev = run & at_end & sck_q;
  assign sck     = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (at_end) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [5:0]        ctl_wdata,
  input  logic              fall_ev,
  output logic              busy,
  output tws_cmd_t          cmd_q,
  output logic              sda_oe,
  output logic              start_ev,
  output logic              zero_ev,
  output logic              done_ev
);
  tws_cmd_t      req;
  logic [CW-1:0] left_q;
  logic          busy_q;
  logic          oe_q;

  always_comb begin
    req     = tws_cmd_t'(ctl_wdata);
    req.cnt = clamp_cnt(req.cnt);
  end

  assign start_ev = ctl_we & ~busy_q;
  assign zero_ev  = start_ev & (req.cnt == '0);
  assign done_ev  = fall_ev & (left_q == CW'(1));
  assign busy     = busy_q;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_ev) begin
      cmd_q <= req;
      if (zero_ev) begin
        oe_q <= ~req.hiz;
      end else begin
        busy_q <= 1'b1;
        left_q <= req.cnt;
        oe_q   <= ~req.rd;
      end
    end else if (fall_ev) begin
      left_q <= left_q - 1'b1;
      if (done_ev) begin
        busy_q <= 1'b0;
        oe_q   <= drive_after(cmd_q.rd, cmd_q.hiz);
      end
    end
  end
endmodule

// File: rtl/tws_shreg.sv
module tws_shreg
  import tws_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  input  logic          busy,
  input  logic          rd,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic          sda_i,
  output logic [DW-1:0] data_q,
  output logic          sda_o
);
  logic rx_q;
  logic load_ev;

  assign load_ev = dat_we & ~busy;
  assign sda_o   = data_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
    end else if (rise_ev) begin
      rx_q <= sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_ev) begin
      data_q <= dat_wdata;
    end else if (fall_ev) begin
      data_q <= shift_step(data_q, rd & rx_q);
    end
  end
endmodule

// File: rtl/tw_eeprom_shifter.sv
module tw_eeprom_shifter
  import tws_pkg::*;
#(
  parameter int HALF_DIV = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [5:0] ctl_wdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  output logic [7:0] ctl_rdata,
  output logic [7:0] dat_rdata,
  output logic       sck_o,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic       sda_i
);
  logic     busy;
  logic     rise_ev;
  logic     fall_ev;
  logic     start_ev;
  logic     zero_ev;
  logic     done_ev;
  tws_cmd_t cmd_q;

  tws_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .sck     (sck_o),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  tws_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .fall_ev   (fall_ev),
    .busy      (busy),
    .cmd_q     (cmd_q),
    .sda_oe    (sda_oe),
    .start_ev  (start_ev),
    .zero_ev   (zero_ev),
    .done_ev   (done_ev)
  );

  tws_shreg u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .busy      (busy),
    .rd        (cmd_q.rd),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .sda_i     (sda_i),
    .data_q    (dat_rdata),
    .sda_o     (sda_o)
  );

  assign ctl_rdata = {busy, 1'b0, cmd_q};
endmodule

// File: rtl/tws_checker.sv
module tws_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_rdata,
  input logic [7:0] dat_rdata,
  input logic       sck_o,
  input logic       sda_o,
  input logic       sda_oe,
  input logic       busy,
  input logic       rise_ev,
  input logic       fall_ev,
  input logic       start_ev,
  input logic       zero_ev,
  input logic       done_ev
);
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_o);

  a_r2_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> sck_o);

  a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !busy && !sck_o);

  a_r4_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ctl_rdata[4] |-> sda_oe);

  a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fall_ev |=> $stable(sda_o) && $stable(dat_rdata));

  a_r5_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_rdata[4] |-> !sda_oe);

  a_r7_zero_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ev |=> !busy && (sda_oe == !ctl_rdata[5]));

  a_r8_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[3:0] <= 4'd8);

  a_r9_busy_locks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_we && !fall_ev |=> $stable(ctl_rdata[5:0]) && busy);

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev && !zero_ev |=> busy && (ctl_rdata[7] == 1'b1));
endmodule

bind tw_eeprom_shifter tws_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_rdata (ctl_rdata),
  .dat_rdata (dat_rdata),
  .sck_o     (sck_o),
  .sda_o     (sda_o),
  .sda_oe    (sda_oe),
  .busy      (busy),
  .rise_ev   (rise_ev),
  .fall_ev   (fall_ev),
  .start_ev  (start_ev),
  .zero_ev   (zero_ev),
  .done_ev   (done_ev)
);

// File: tb/tb_tw_eeprom_shifter.sv
`timescale 1ns/1ps
module tb_tw_eeprom_shifter;
  localparam int HALF = 50;
  localparam int TCLK = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic       dat_we = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [7:0] dat_rdata;
  logic       sck_o;
  logic       sda_o;
  logic       sda_oe;
  logic       sda_i = 1'b0;

  int checks = 0;
  int bad = 0;
  int op_rises = 0;
  longint last_rise = 0;
  bit exp_q[$];
  bit rx_bits[$];

  always #(TCLK/2) clk = ~clk;

  tw_eeprom_shifter #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .ctl_rdata(ctl_rdata),
    .dat_rdata(dat_rdata), .sck_o(sck_o), .sda_o(sda_o), .sda_oe(sda_oe),
    .sda_i(sda_i)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard at each SCK rise while the driver is on.
  always @(posedge sck_o) begin
    #1;
    if (op_rises > 0) chk("R2 sck period", $time - last_rise, 2 * HALF * TCLK);
    last_rise = $time;
    op_rises++;
    if (sda_oe) begin
      if (exp_q.size() == 0) chk("R4 unexpected serial bit", 1, 0);
      else chk("R4 serial bit", sda_o, exp_q.pop_front());
    end
  end

  // EEPROM model: presents the next receive bit after each falling edge.
  always @(negedge sck_o) begin
    if (rx_bits.size() > 0) sda_i = rx_bits.pop_front();
  end

  task automatic push_tx(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(d[7-i]);
  endtask

  task automatic push_rx(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) rx_bits.push_back(v[n-1-i]);
    sda_i = rx_bits.pop_front();
  endtask

  task automatic load_data(input logic [7:0] d);
    @(negedge clk); dat_we = 1'b1; dat_wdata = d;
    @(negedge clk); dat_we = 1'b0;
  endtask

  // Driver: issues one control write and times busy; optionally pokes both
  // strobes mid-operation or loads data in the starting cycle.
  task automatic run_op(input logic [5:0] cmd, input int ncnt, input int poke_at,
                        input bit with_dat, input logic [7:0] dval);
    int n;
    op_rises = 0;
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = cmd;
    if (with_dat) begin dat_we = 1'b1; dat_wdata = dval; end
    @(negedge clk);
    ctl_we = 1'b0; dat_we = 1'b0;
    if (ncnt == 0) begin
      chk("R7 busy stays low", ctl_rdata[7], 0);
      repeat (3 * HALF) @(negedge clk);
      chk("R7 no sck pulse", op_rises, 0);
    end else begin
      chk("R3 busy set", ctl_rdata[7], 1);
      n = 0;
      while (ctl_rdata[7] === 1'b1 && n < 4000) begin
        n++;
        if (n == poke_at) begin
          ctl_we = 1'b1; ctl_wdata = 6'h12; dat_we = 1'b1; dat_wdata = 8'hFF;
        end else begin
          ctl_we = 1'b0; dat_we = 1'b0;
        end
        @(negedge clk);
      end
      ctl_we = 1'b0; dat_we = 1'b0;
      chk("R3 busy length", n, 2 * HALF * ncnt);
      chk("R3 pulse count", op_rises, ncnt);
      chk("R2 sck idle low", sck_o, 0);
    end
  endtask

  initial begin
    #(longint'(200000) * TCLK);
    checks++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ctl_rdata", ctl_rdata, 0);
    chk("R1 dat_rdata", dat_rdata, 0);
    chk("R1 sck_o", sck_o, 0);
    chk("R1 sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R6 R11: 8-bit transmit, release clear
    load_data(8'hA5); push_tx(8'hA5, 8);
    run_op(6'h08, 8, 0, 0, 8'h00);
    chk("R4 all bits sent", exp_q.size(), 0);
    chk("R4 zero fill", dat_rdata, 8'h00);
    chk("R6 drive kept", sda_oe, 1);
    chk("R11 readback", ctl_rdata, 8'h08);

    // R4 R6: 3-bit transmit with release
    load_data(8'hD7); push_tx(8'hD7, 3);
    run_op(6'h23, 3, 0, 0, 8'h00);
    chk("R4 all bits sent 3", exp_q.size(), 0);
    chk("R4 partial shift", dat_rdata, 8'hB8);
    chk("R6 released", sda_oe, 0);
    chk("R11 readback hiz", ctl_rdata, 8'h23);

    // R5: 8-bit receive
    load_data(8'h00); push_rx(8'h3C, 8);
    run_op(6'h18, 8, 0, 0, 8'h00);
    chk("R5 received byte", dat_rdata, 8'h3C);
    chk("R6 no drive after read", sda_oe, 0);

    // R7: zero-length reclaim
    run_op(6'h00, 0, 0, 0, 8'h00);
    chk("R7 driver on", sda_oe, 1);
    chk("R7 data unchanged", dat_rdata, 8'h3C);

    // R5: 4-bit receive into low bits
    load_data(8'h5F); push_rx(8'h0A, 4);
    run_op(6'h34, 4, 0, 0, 8'h00);
    chk("R5 low nibble fill", dat_rdata, 8'hFA);
    chk("R5 driver off", sda_oe, 0);

    // R7: zero-length with release
    run_op(6'h00, 0, 0, 0, 8'h00);
    run_op(6'h20, 0, 0, 0, 8'h00);
    chk("R7 released by zero op", sda_oe, 0);
    chk("R7 data unchanged 2", dat_rdata, 8'hFA);

    // R8: count 15 treated as 8
    load_data(8'h69); push_tx(8'h69, 8);
    run_op(6'h0F, 8, 0, 0, 8'h00);
    chk("R8 clamped readback", ctl_rdata, 8'h08);
    chk("R8 all bits sent", exp_q.size(), 0);

    // R9: writes during busy ignored
    load_data(8'h9C); push_tx(8'h9C, 4);
    run_op(6'h04, 4, 30, 0, 8'h00);
    chk("R9 data not reloaded", dat_rdata, 8'hC0);
    chk("R9 control not replaced", ctl_rdata, 8'h04);
    chk("R9 bits sent", exp_q.size(), 0);

    // R10: data and control written in the same cycle
    push_tx(8'h3E, 6);
    run_op(6'h06, 6, 0, 1, 8'h3E);
    chk("R10 new data shifted", dat_rdata, 8'h80);
    chk("R10 bits sent", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule